// File: doc/BRIEF.md
# Dual-Mode Crosspoint Routing Selector

This block produces the final per-output input select and output enable for a four-lane crosspoint, and routes four single-bit input lanes to four output lanes. It has two control sources. In register mode, with the mode pin low, it passes through the active configuration bank held by a neighbouring register block. In direct mode, with the mode pin high, it decodes the address and data pins as live controls, gated by an active-low chip select. In this mode it behaves as two independent 2×2 switches: outputs 0 and 1 reach only inputs 0 and 1, and outputs 2 and 3 reach only inputs 2 and 3.

The mode pin passes through a synchronizer. When direct mode ends, the block sends a one-cycle capture strobe to the register block. The strobe carries the routing and enables that were last applied, so that the register block can write them into its active bank. The block also gates the active-low write, update and read controls into active-high strobes for the register block. These strobes are blocked in direct mode.

Top module: `xpt_route_sel`

## Requirements
- R1: In register mode, with no capture strobe, out_sel equals bank_sel and out_en equals bank_en. out_sel[2n+1:2n] is the input index for output n.
- R2: In direct mode with cs_n low, out_en[n] equals addr_pins[n], where 1 means enabled. The change shows with no clock edge in between.
- R3: In direct mode with cs_n low, output n for n in {0,1} selects input data_pins[n] (0 gives input 0, 1 gives input 1). Output n for n in {2,3} selects input 2 + data_pins[n]. No output ever selects an input outside its own pair.
- R4: In direct mode with cs_n high, out_sel and out_en hold the values applied at the last clock edge at which cs_n was low, whatever the pins do.
- R5: A rise of mode_pin takes effect after two rising clock edges. From then on the outputs follow the live pins, with no extra edge.
- R6: A fall of mode_pin raises cap_strobe for exactly one cycle, after two rising clock edges. cap_sel and cap_en carry the held direct routing in the same encoding as out_sel and out_en. During that cycle the outputs still show the held routing. From the next cycle they follow the bank.
- R7: lane_out[n] equals lane_in[out_sel[2n+1:2n]] when out_en[n] is 1, and 0 when out_en[n] is 0.
- R8: reg_we, reg_upd and reg_re are the inversions of we_n, upd_n and re_n only in register mode with cs_n low and rst_n high. Otherwise they are 0, in direct mode in particular.
- R9: While rst_n is low, out_en and lane_out are all 0 in either mode. Reset sets the held direct routing to output n from input n, with all outputs disabled. The synchronized mode resets to register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low reset |
| mode_pin | input | 1 | Mode select, asynchronous: 0 register mode, 1 direct mode |
| cs_n | input | 1 | Active-low chip select |
| addr_pins | input | 4 | Address pins; direct-mode output enables |
| data_pins | input | 4 | Data pins; direct-mode one-bit selects |
| we_n | input | 1 | Active-low write request |
| upd_n | input | 1 | Active-low update request |
| re_n | input | 1 | Active-low read request |
| bank_sel | input | 8 | Active bank selects, two bits per output |
| bank_en | input | 4 | Active bank enables |
| lane_in | input | 4 | Input lane bits |
| out_sel | output | 8 | Final per-output input index |
| out_en | output | 4 | Final per-output enable |
| lane_out | output | 4 | Routed output lane bits |
| reg_we | output | 1 | Gated write strobe to register block |
| reg_upd | output | 1 | Gated update strobe to register block |
| reg_re | output | 1 | Gated read strobe to register block |
| cap_strobe | output | 1 | One-cycle capture request on leaving direct mode |
| cap_sel | output | 8 | Captured direct-mode selects |
| cap_en | output | 4 | Captured direct-mode enables |

## Verification
The bench sweeps every address and data combination in direct mode across every lane pattern. A decoder that let an output cross into the other pair, or that got the bit sense of a select wrong, fails the sweep at once. Chip-select hold is tested by changing the pins while cs_n is high; a design that tracked the pins anyway would show the new routing. The mode exit is checked cycle by cycle. This catches a strobe that lasts two cycles or comes on the wrong edge, a capture of the live pins in place of the held state, and an output that drops to the bank one cycle early. Reset is checked in both modes, against a design that leaves enables live during reset.

// File: rtl/xpt_route_sel.sv
module xpt_route_sel #(
  parameter bit DEFAULT_DIRECT = 1'b0,
  parameter int SYNC_STAGES    = 2,
  parameter int LANES          = 4,
  localparam int SW            = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_pin,
  input  logic               cs_n,
  input  logic [LANES-1:0]   addr_pins,
  input  logic [LANES-1:0]   data_pins,
  input  logic               we_n,
  input  logic               upd_n,
  input  logic               re_n,
  input  logic [LANES*SW-1:0] bank_sel,
  input  logic [LANES-1:0]   bank_en,
  input  logic [LANES-1:0]   lane_in,
  output logic [LANES*SW-1:0] out_sel,
  output logic [LANES-1:0]   out_en,
  output logic [LANES-1:0]   lane_out,
  output logic               reg_we,
  output logic               reg_upd,
  output logic               reg_re,
  output logic               cap_strobe,
  output logic [LANES*SW-1:0] cap_sel,
  output logic [LANES-1:0]   cap_en
);

  localparam logic [LANES-1:0] BUF_MAP = 4'b1010;

  logic [SYNC_STAGES-1:0] msync;
  logic mode_s, mode_d, use_direct, ctl_ok;
  logic [LANES-1:0] hold_sel, hold_en, src_d, src_a;

  function automatic logic [LANES*SW-1:0] pair_decode(input logic [LANES-1:0] d);
    pair_decode = {1'b1, d[3], 1'b1, d[2], 1'b0, d[1], 1'b0, d[0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msync <= {SYNC_STAGES{DEFAULT_DIRECT}};
      mode_d <= DEFAULT_DIRECT;
    end else begin
      msync <= {msync[SYNC_STAGES-2:0], mode_pin};
      mode_d <= mode_s;
    end
  end

  assign mode_s = msync[SYNC_STAGES-1];
  assign cap_strobe = mode_d & ~mode_s;
  assign use_direct = mode_s | cap_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_sel <= BUF_MAP;
      hold_en  <= '0;
    end else if (mode_s && !cs_n) begin
      hold_sel <= data_pins;
      hold_en  <= addr_pins;
    end
  end

  assign src_d = (mode_s && !cs_n) ? data_pins : hold_sel;
  assign src_a = (mode_s && !cs_n) ? addr_pins : hold_en;

  assign out_sel = use_direct ? pair_decode(src_d) : bank_sel;
  assign out_en  = rst_n ? (use_direct ? src_a : bank_en) : '0;
  assign cap_sel = pair_decode(hold_sel);
  assign cap_en  = hold_en;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_out[g] = out_en[g] & lane_in[out_sel[g*SW +: SW]];
    end
  endgenerate

  assign ctl_ok  = rst_n & ~mode_s & ~cs_n;
  assign reg_we  = ctl_ok & ~we_n;
  assign reg_upd = ctl_ok & ~upd_n;
  assign reg_re  = ctl_ok & ~re_n;

  p_pair_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    use_direct |-> (out_sel[1] == 1'b0 && out_sel[3] == 1'b0 &&
                    out_sel[5] == 1'b1 && out_sel[7] == 1'b1));

  p_hold_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && $past(mode_s) && cs_n && $past(cs_n)) |-> ($stable(out_sel) && $stable(out_en)));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> !cap_strobe);

  p_strobe_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> (out_sel == cap_sel && out_en == cap_en));

  p_dark_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_out & ~out_en) == '0));

  p_no_ctl_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s |-> !(reg_we || reg_upd || reg_re));

  p_reset_dark_r9: assert property (@(posedge clk)
    !rst_n |-> (out_en == '0 && lane_out == '0));

endmodule

// File: tb/xpt_route_sel_bench.sv
module xpt_route_sel_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, mode_pin = 0, cs_n = 1;
  logic [3:0] addr_pins = 0, data_pins = 0, bank_en = 0, lane_in = 0;
  logic we_n = 1, upd_n = 1, re_n = 1;
  logic [7:0] bank_sel = 0;
  logic [7:0] out_sel, cap_sel;
  logic [3:0] out_en, lane_out, cap_en;
  logic reg_we, reg_upd, reg_re, cap_strobe;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_route_sel u_xpt_route_sel (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .cs_n(cs_n),
    .addr_pins(addr_pins), .data_pins(data_pins), .we_n(we_n), .upd_n(upd_n), .re_n(re_n),
    .bank_sel(bank_sel), .bank_en(bank_en), .lane_in(lane_in),
    .out_sel(out_sel), .out_en(out_en), .lane_out(lane_out),
    .reg_we(reg_we), .reg_upd(reg_upd), .reg_re(reg_re),
    .cap_strobe(cap_strobe), .cap_sel(cap_sel), .cap_en(cap_en));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] exp_dec(input logic [3:0] d);
    logic [7:0] r = 0;
    for (int n = 0; n < 4; n++) r[2*n +: 2] = 2'((n >= 2 ? 2 : 0) + int'(d[n]));
    return r;
  endfunction

  function automatic logic [3:0] exp_lane(input logic [7:0] s, input logic [3:0] e, input logic [3:0] li);
    logic [3:0] r = 0;
    for (int n = 0; n < 4; n++) r[n] = e[n] ? li[s[2*n +: 2]] : 1'b0;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bank_en = 4'hF; bank_sel = 8'h1B; lane_in = 4'hF; cs_n = 0; we_n = 0;
    repeat (3) tick();
    check("R9 reset out_en", 32'(out_en), 0);
    check("R9 reset lane_out", 32'(lane_out), 0);
    check("R8 reset reg_we", 32'(reg_we), 0);
    we_n = 1; cs_n = 1;
    rst_n = 1;
    tick(); tick();
    check("R1 after reset sel", 32'(out_sel), 32'h1B);
    check("R1 after reset en", 32'(out_en), 32'hF);

    for (int k = 0; k < 64; k++) begin
      bank_sel = 8'((k * 53 + 7) % 256);
      bank_en = 4'(k % 16);
      #1;
      check("R1 bank sel", 32'(out_sel), 32'(bank_sel));
      check("R1 bank en", 32'(out_en), 32'(bank_en));
      for (int li = 0; li < 16; li++) begin
        lane_in = 4'(li); #1;
        check("R7 register lane", 32'(lane_out), 32'(exp_lane(bank_sel, bank_en, lane_in)));
      end
    end
    tick();

    cs_n = 0; we_n = 0; upd_n = 0; re_n = 1; #1;
    check("R8 reg we", 32'(reg_we), 1);
    check("R8 reg upd", 32'(reg_upd), 1);
    check("R8 reg re", 32'(reg_re), 0);
    cs_n = 1; #1;
    check("R8 cs high we", 32'(reg_we), 0);
    we_n = 1; upd_n = 1;
    tick();

    bank_sel = 8'h1B; bank_en = 4'b1000;
    cs_n = 0; addr_pins = 4'b0101; data_pins = 4'b0011; mode_pin = 1;
    tick();
    check("R5 one edge still bank", 32'(out_en), 32'h8);
    tick();
    check("R5 direct en", 32'(out_en), 32'h5);
    check("R5 direct sel", 32'(out_sel), 32'(exp_dec(4'b0011)));
    we_n = 0; upd_n = 0; re_n = 0; #1;
    check("R8 direct we", 32'(reg_we), 0);
    check("R8 direct upd", 32'(reg_upd), 0);
    check("R8 direct re", 32'(reg_re), 0);
    we_n = 1; upd_n = 1; re_n = 1;

    for (int a = 0; a < 16; a++)
      for (int d = 0; d < 16; d++) begin
        addr_pins = 4'(a); data_pins = 4'(d); #1;
        check("R2 direct en", 32'(out_en), 32'(a));
        check("R3 direct sel", 32'(out_sel), 32'(exp_dec(4'(d))));
        for (int li = 0; li < 16; li++) begin
          lane_in = 4'(li); #1;
          check("R7 direct lane", 32'(lane_out), 32'(exp_lane(exp_dec(4'(d)), 4'(a), 4'(li))));
        end
      end

    @(negedge clk);
    addr_pins = 4'hF; data_pins = 4'b0101;
    tick();
    cs_n = 1; addr_pins = 4'h0; data_pins = 4'hA; #1;
    check("R4 hold en", 32'(out_en), 32'hF);
    check("R4 hold sel", 32'(out_sel), 32'h B1);
    tick(); tick();
    check("R4 hold en later", 32'(out_en), 32'hF);
    check("R4 hold sel later", 32'(out_sel), 32'hB1);

    bank_sel = 8'h00; bank_en = 4'b0010;
    mode_pin = 0;
    tick();
    check("R6 no strobe after one edge", 32'(cap_strobe), 0);
    tick();
    check("R6 strobe", 32'(cap_strobe), 1);
    check("R6 cap sel", 32'(cap_sel), 32'hB1);
    check("R6 cap en", 32'(cap_en), 32'hF);
    check("R6 strobe cycle sel", 32'(out_sel), 32'hB1);
    check("R6 strobe cycle en", 32'(out_en), 32'hF);
    tick();
    check("R6 strobe gone", 32'(cap_strobe), 0);
    check("R6 bank sel", 32'(out_sel), 32'h00);
    check("R6 bank en", 32'(out_en), 32'h2);

    mode_pin = 1; cs_n = 0; addr_pins = 4'hF; lane_in = 4'hF;
    tick(); tick();
    check("R2 direct before reset", 32'(out_en), 32'hF);
    rst_n = 0; #1;
    check("R9 direct reset en", 32'(out_en), 0);
    check("R9 direct reset lane", 32'(lane_out), 0);
    tick();
    cs_n = 1; rst_n = 1;
    tick(); tick();
    check("R9 buffer map", 32'(out_sel), 32'hE4);
    check("R9 disabled", 32'(out_en), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule